// File: doc/BRIEF.md
# Video Field Capture Sequencer

This block runs in the 4x-subcarrier sample clock domain (nominally 14.318 MHz) and sequences the capture of one interlaced video field into an external sequential-access field memory. A single field holds every other line of a frame. Once armed by the host, the block waits for the sync-lock condition together with a field-start marker. It then resets the memory's write pointer and streams 8-bit samples into the memory at the full sample rate until the whole field is stored, and writing stops there.

After the field is stored, the block resets the memory's read pointer and moves to readout. The host reads the field back one byte at a time, at whatever slower pace it chooses. Each host request pulse produces one read strobe. That strobe advances the memory's read pointer by one sample, and a data-valid pulse returns the byte. Two status flags tell the host whether a capture is in progress or a field is waiting. A low-power input forces the sequencer idle with every memory strobe inactive.

The field size is set by the parameters `LINES` (default 263) and `SAMPLES_PER_LINE` (default 910). The field length is their product. The `rst_n` input is assumed to be asserted asynchronously and already released in step with `clk` by the surrounding reset logic.

Top module: `field_capture_seq`

## Requirements
- R1: While reset is held and directly after it, every memory strobe, `busy`, `done` and `host_valid` are low, and `host_data` is 0.
- R2: A `cap_req` pulse seen while idle makes `busy` high from the next cycle on. No write strobe is issued until a clock edge samples `sync_locked` and `field_start` both high.
- R3: The cycle after the edge that samples `sync_locked` and `field_start` both high while armed, `mem_wrst` and `mem_wck_en` are high for exactly one cycle, with `mem_we` low.
- R4: Right after the write-reset cycle, `mem_we` and `mem_wck_en` are high for exactly LINES*SAMPLES_PER_LINE consecutive cycles, and then both go low.
- R5: The cycle after the last write, `mem_rrst` is high for one cycle. From the following cycle `done` is high and `busy` is low. `done` and `busy` are never high together, and no write happens while `done` is high.
- R6: While `done` is high, a `host_req` sampled at a clock edge makes `mem_rstb` high for exactly the next cycle. `host_valid` is then high for one cycle, two cycles after that edge. In that cycle `host_data` carries the byte the memory presented in the cycle after the strobe.
- R7: A `host_req` sampled while a read is in flight (the strobe cycle or the cycle after it) is ignored. A request held high is therefore served once every three cycles.
- R8: The valid pulse that returns the LINES*SAMPLES_PER_LINE-th byte also ends readout: `done` is low from that cycle and the block is idle.
- R9: `cap_req` has no effect while `busy` or `done` is high. The capture or readout in progress continues unchanged.
- R10: While `low_power` is high, every memory strobe, `busy` and `done` are low in that same cycle. The block is idle on the following cycle, any capture or readout is abandoned, and `cap_req` is ignored.
- R11: `host_data` changes only together with a `host_valid` pulse and holds its value between pulses.
- R12: `host_req` while idle, and `sync_locked` with `field_start` while not armed, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 4x colour subcarrier |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| low_power | input | 1 | Forces idle with all memory strobes inactive |
| cap_req | input | 1 | Host pulse requesting a field capture |
| sync_locked | input | 1 | Video sync lock indication |
| field_start | input | 1 | Marks the first sample of a field |
| mem_wrst | output | 1 | Field memory write-pointer reset |
| mem_wck_en | output | 1 | Field memory write pixel-clock enable |
| mem_we | output | 1 | Field memory write enable |
| mem_rrst | output | 1 | Field memory read-pointer reset |
| mem_rstb | output | 1 | Field memory read strobe, advances the read pointer by one |
| mem_rdata | input | DATA_W | Sample presented by the field memory |
| host_req | input | 1 | Host pulse requesting the next byte |
| host_valid | output | 1 | One-cycle pulse: `host_data` holds a new byte |
| host_data | output | DATA_W | Last byte read from the field |
| busy | output | 1 | Capture armed or in progress |
| done | output | 1 | A stored field is ready for readout |

## Verification
The results have fixed latencies. The write reset follows one cycle after the edge that sees lock and field start. The write burst starts the cycle after that and lasts the field length. The read-pointer reset takes one cycle, and `done` follows it. A read strobe appears one cycle after the edge that takes a request, and its valid pulse and byte two cycles after it. The effect of `low_power` on strobes and status is combinational within the same cycle. The bench keeps a behavioural model of phases, counters and the in-flight read that advances on each rising edge with the inputs that edge samples. On each falling edge it compares every output against the model, so each result is checked in exactly the cycle it is due and in every other cycle as well.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WRST,
    ST_WRITE,
    ST_RRST,
    ST_READ
  } fcs_state_e;
endpackage

// File: rtl/fcs_counter.sv
// Sample counter: clears, increments on enable, flags the last position.
module fcs_counter #(
  parameter int COUNT = 239330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(COUNT - 1));
endmodule

// File: rtl/fcs_ctrl.sv
// Capture / readout phase sequencer.
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_power,
  input  logic       cap_req,
  input  logic       sync_locked,
  input  logic       field_start,
  input  logic       wr_last,
  input  logic       rd_done,
  output fcs_state_e state
);
  fcs_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (cap_req) state_d = ST_ARMED;
      ST_ARMED: if (sync_locked && field_start) state_d = ST_WRST;
      ST_WRST:  state_d = ST_WRITE;
      ST_WRITE: if (wr_last) state_d = ST_RRST;
      ST_RRST:  state_d = ST_READ;
      ST_READ:  if (rd_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (low_power) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/fcs_rd_pipe.sv
// Read pacing: request -> strobe -> memory data -> valid pulse.
module fcs_rd_pipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              host_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_stb,
  output logic              rd_pend,
  output logic              host_valid,
  output logic [DATA_W-1:0] host_data
);
  logic              stb_d, pend_d, vld_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    stb_d  = en && host_req && !rd_stb && !rd_pend;
    pend_d = rd_stb && en;
    vld_d  = rd_pend && en;
    data_d = vld_d ? mem_rdata : host_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb     <= 1'b0;
      rd_pend    <= 1'b0;
      host_valid <= 1'b0;
      host_data  <= '0;
    end else begin
      rd_stb     <= stb_d;
      rd_pend    <= pend_d;
      host_valid <= vld_d;
      host_data  <= data_d;
    end
  end
endmodule

// File: rtl/field_capture_seq.sv
// Field capture sequencer top.
module field_capture_seq
  import fcs_pkg::*;
#(
  parameter int LINES            = 263,
  parameter int SAMPLES_PER_LINE = 910,
  parameter int DATA_W           = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_power,
  input  logic              cap_req,
  input  logic              sync_locked,
  input  logic              field_start,
  output logic              mem_wrst,
  output logic              mem_wck_en,
  output logic              mem_we,
  output logic              mem_rrst,
  output logic              mem_rstb,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              host_req,
  output logic              host_valid,
  output logic [DATA_W-1:0] host_data,
  output logic              busy,
  output logic              done
);
  localparam int FIELD_LEN = LINES * SAMPLES_PER_LINE;

  fcs_state_e state;
  logic       wr_last, rd_last, rd_done;
  logic       rd_en, rd_stb, rd_pend;
  logic       awake;

  assign awake   = !low_power;
  assign rd_en   = (state == ST_READ) && awake;
  assign rd_done = rd_pend && rd_last;

  fcs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .low_power   (low_power),
    .cap_req     (cap_req),
    .sync_locked (sync_locked),
    .field_start (field_start),
    .wr_last     (wr_last),
    .rd_done     (rd_done),
    .state       (state)
  );

  fcs_counter #(.COUNT(FIELD_LEN)) u_wr_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == ST_WRST),
    .inc   ((state == ST_WRITE) && awake),
    .last  (wr_last)
  );

  fcs_counter #(.COUNT(FIELD_LEN)) u_rd_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == ST_RRST),
    .inc   (rd_pend && rd_en),
    .last  (rd_last)
  );

  fcs_rd_pipe #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rd_en),
    .host_req   (host_req),
    .mem_rdata  (mem_rdata),
    .rd_stb     (rd_stb),
    .rd_pend    (rd_pend),
    .host_valid (host_valid),
    .host_data  (host_data)
  );

  always_comb begin
    mem_wrst   = awake && (state == ST_WRST);
    mem_wck_en = awake && ((state == ST_WRST) || (state == ST_WRITE));
    mem_we     = awake && (state == ST_WRITE);
    mem_rrst   = awake && (state == ST_RRST);
    mem_rstb   = awake && rd_stb;
    busy       = awake && ((state == ST_ARMED) || (state == ST_WRST) ||
                           (state == ST_WRITE) || (state == ST_RRST));
    done       = rd_en;
  end
endmodule

// File: rtl/fcs_checker.sv
// Temporal checks on the sequencer ports.
module fcs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              low_power,
  input logic              sync_locked,
  input logic              field_start,
  input logic              mem_wrst,
  input logic              mem_we,
  input logic              mem_rstb,
  input logic              busy,
  input logic              done,
  input logic              host_valid,
  input logic [DATA_W-1:0] host_data
);
  p_wrst_after_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wrst) |-> $past(sync_locked && field_start));

  p_wrst_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n || low_power)
    mem_wrst |=> mem_we);

  p_no_write_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && (mem_rstb || done)));

  p_status_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rst_n || low_power)
    mem_rstb |-> ##2 host_valid);

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rstb |=> !mem_rstb);

  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> (!busy && !done && !mem_we && !mem_rstb));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_data) |-> host_valid);
endmodule

bind field_capture_seq fcs_checker #(.DATA_W(DATA_W)) u_fcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .low_power   (low_power),
  .sync_locked (sync_locked),
  .field_start (field_start),
  .mem_wrst    (mem_wrst),
  .mem_we      (mem_we),
  .mem_rstb    (mem_rstb),
  .busy        (busy),
  .done        (done),
  .host_valid  (host_valid),
  .host_data   (host_data)
);

// File: tb/field_capture_seq_test.sv
`timescale 1ns/100ps
module field_capture_seq_test;
  localparam int LINES = 3;
  localparam int SPL   = 5;
  localparam int FIELD = LINES * SPL;

  logic clk = 1'b0;
  logic rst_n, low_power, cap_req, sync_locked, field_start, host_req;
  logic mem_wrst, mem_wck_en, mem_we, mem_rrst, mem_rstb, host_valid, busy, done;
  logic [7:0] mem_rdata, host_data;

  int tests = 0;
  int fails = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  field_capture_seq #(.LINES(LINES), .SAMPLES_PER_LINE(SPL), .DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .low_power(low_power), .cap_req(cap_req),
    .sync_locked(sync_locked), .field_start(field_start),
    .mem_wrst(mem_wrst), .mem_wck_en(mem_wck_en), .mem_we(mem_we),
    .mem_rrst(mem_rrst), .mem_rstb(mem_rstb), .mem_rdata(mem_rdata),
    .host_req(host_req), .host_valid(host_valid), .host_data(host_data),
    .busy(busy), .done(done)
  );

  function automatic int byte_of(int idx, int capno);
    return (idx * 7 + 3 + capno * 11) % 256;
  endfunction

  // Field memory model
  logic [7:0] mem [FIELD];
  int wptr = 0, rptr = 0, mcap = 0;
  always @(posedge clk) begin
    if (!rst_n) mem_rdata <= 8'd0;
    else begin
      if (mem_wrst) begin wptr = 0; mcap++; end
      if (mem_we && wptr < FIELD) begin mem[wptr] = 8'(byte_of(wptr, mcap)); wptr++; end
      if (mem_rrst) rptr = 0;
      if (mem_rstb && rptr < FIELD) begin mem_rdata <= mem[rptr]; rptr++; end
    end
  end

  // Reference model: 0 idle,1 armed,2 wrst,3 write,4 rrst,5 read
  int m_ph = 0, m_wc = 0, m_rc = 0, m_age = 0, m_vld = 0, m_data = 0, m_cap = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_wc = 0; m_rc = 0; m_age = 0; m_vld = 0; m_data = 0; m_cap = 0;
    end else if (low_power) begin
      m_ph = 0; m_age = 0; m_vld = 0;
    end else begin
      int n_age, n_vld;
      bit en;
      en = (m_ph == 5);
      n_age = 0; n_vld = 0;
      if (en && m_age == 2) begin
        n_vld = 1; m_data = byte_of(m_rc, m_cap); m_rc++;
      end
      if (en && m_age == 1) n_age = 2;
      else if (en && m_age == 0 && host_req) n_age = 1;
      case (m_ph)
        0: if (cap_req) m_ph = 1;
        1: if (sync_locked && field_start) m_ph = 2;
        2: begin m_ph = 3; m_wc = 0; m_cap++; end
        3: begin m_wc++; if (m_wc == FIELD) m_ph = 4; end
        4: begin m_ph = 5; m_rc = 0; end
        default: if (n_vld == 1 && m_rc == FIELD) m_ph = 0;
      endcase
      m_age = n_age; m_vld = n_vld;
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s actual=%0d expected=%0d at %0t", req, cur, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int aw;
      aw = low_power ? 0 : 1;
      chk("R3", "mem_wrst",   int'(mem_wrst),   aw & int'(m_ph == 2));
      chk("R4", "mem_wck_en", int'(mem_wck_en), aw & int'(m_ph == 2 || m_ph == 3));
      chk("R4", "mem_we",     int'(mem_we),     aw & int'(m_ph == 3));
      chk("R5", "mem_rrst",   int'(mem_rrst),   aw & int'(m_ph == 4));
      chk("R2", "busy",       int'(busy),       aw & int'(m_ph >= 1 && m_ph <= 4));
      chk("R5", "done",       int'(done),       aw & int'(m_ph == 5));
      chk("R6", "mem_rstb",   int'(mem_rstb),   aw & int'(m_age == 1));
      chk("R6", "host_valid", int'(host_valid), m_vld);
      chk("R11", "host_data", int'(host_data),  m_data);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_cap();  cap_req = 1'b1;     step(1); cap_req = 1'b0;     endtask
  task automatic pulse_fs();   field_start = 1'b1; step(1); field_start = 1'b0; endtask
  task automatic pulse_host(); host_req = 1'b1;    step(1); host_req = 1'b0;    endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (%s)", cur);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; low_power = 1'b0; cap_req = 1'b0; sync_locked = 1'b0;
    field_start = 1'b0; host_req = 1'b0;
    step(3);
    // R1: reset state
    chk("R1", "busy",       int'(busy),       0);
    chk("R1", "done",       int'(done),       0);
    chk("R1", "mem_we",     int'(mem_we),     0);
    chk("R1", "host_data",  int'(host_data),  0);
    rst_n = 1'b1;
    step(3);
    // R12: no effect while idle
    cur = "R12";
    pulse_host(); step(3);
    sync_locked = 1'b1; pulse_fs(); step(3);
    // R2: armed waits for lock and field start together
    cur = "R2";
    sync_locked = 1'b0;
    pulse_cap(); step(2);
    pulse_fs(); step(2);
    sync_locked = 1'b1; step(3);
    // R3/R4/R5: capture
    cur = "R3";
    pulse_fs();
    cur = "R9";
    step(3); pulse_cap();
    cur = "R4";
    step(FIELD + 4);
    // R6/R11: paced reads
    cur = "R6";
    pulse_host(); step(5);
    pulse_host(); step(2);
    cur = "R11";
    step(6);
    // R7: request held high
    cur = "R7";
    host_req = 1'b1; step(12); host_req = 1'b0;
    cur = "R9";
    pulse_cap(); step(3);
    // R8: drain the field
    cur = "R8";
    for (int i = 0; i < FIELD; i++) begin pulse_host(); step(2); end
    step(5);
    // R10: low power aborts a write
    cur = "R10";
    pulse_cap(); pulse_fs(); step(5);
    low_power = 1'b1; step(3);
    pulse_cap(); step(2);
    low_power = 1'b0; step(4);
    // R10: low power aborts a readout
    pulse_cap(); pulse_fs(); step(FIELD + 5);
    pulse_host(); step(4);
    pulse_host(); step(1);
    low_power = 1'b1; step(2); low_power = 1'b0; step(3);
    pulse_host(); step(3);
    // R4/R8: full capture and readout once more
    cur = "R8";
    pulse_cap(); pulse_fs(); step(FIELD + 5);
    host_req = 1'b1; step(3 * FIELD + 6); host_req = 1'b0;
    step(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule